// File: doc/BRIEF.md
# Packed Four-Lane Add/Subtract with Guard-Bit Clamp

This unit adds or subtracts two 64-bit packed operands as four independent 16-bit lanes. Each lane is read as a fixed-point value with two guard bits above a 14-bit fraction. The lane arithmetic itself wraps modulo 2^16, with no carry or borrow passed between lanes. Only after that does the unit look at the two guard bits of each lane and clamp the lane into the unsigned 14-bit fraction range.

A lane whose guard bits show positive overflow is forced to the largest fraction. A lane whose guard bits show a negative result is forced to zero. The one guard pattern that correct use never produces is also forced to the largest fraction, and a per-lane flag marks it. The result and the flags are held in a single register stage. They appear one clock after an accepted input, with an output valid alongside them.

Top module: `pk_clamp_addsub`

## Requirements
- R1: Lane i of every packed bus occupies bits 16*i+15 down to 16*i, so lane 0 is bits 15:0 and lane 3 is bits 63:48; bit i of the flag bus belongs to lane i.
- R2: With `op_sub` = 0 each lane computes a + b modulo 2^16, and no carry enters the neighbouring lane.
- R3: With `op_sub` = 1 each lane computes a - b modulo 2^16, and no borrow enters the neighbouring lane.
- R4: A lane result whose bits 15:14 are 00 is passed to the output unchanged.
- R5: A lane result whose bits 15:14 are 01 is output as 0x3FFF, with its flag low.
- R6: A lane result whose bits 15:14 are 11 is output as 0x0000, with its flag low.
- R7: A lane result whose bits 15:14 are 10 is output as 0x3FFF, and that lane's flag is high in the same cycle as the data.
- R8: `out_valid` is high exactly one clock after a clock on which `in_valid` was high; the flags are all low whenever `out_valid` is low.
- R9: After a clock with `in_valid` low, `out_data` keeps its previous value.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_flag` and `out_data` to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sub | input | 1 | 0 = lane add, 1 = lane subtract (a - b) |
| opnd_a | input | 64 | First packed operand, four 16-bit lanes |
| opnd_b | input | 64 | Second packed operand, four 16-bit lanes |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 64 | Registered clamped lane results |
| out_flag | output | 4 | Per-lane marker for the illegal guard pattern 10 |

## Verification
Every result is due exactly one rising edge after the cycle its operands were presented. The bench drives inputs on the falling edge and samples `out_valid`, `out_data` and `out_flag` on the next falling edge, which is half a period after the register has loaded. A cycle with `in_valid` low is checked at that same point for a low valid, low flags and held data. The effect of reset is likewise checked one edge after `rst` is raised.

// File: rtl/pk_clamp_pkg.sv
package pk_clamp_pkg;

    localparam int unsigned LANE_W_DEF = 16;
    localparam int unsigned LANES_DEF  = 4;

    // Guard-bit patterns of a lane result
    typedef enum logic [1:0] {
        GRD_INRANGE = 2'b00,
        GRD_POSOVF  = 2'b01,
        GRD_ILLEGAL = 2'b10,
        GRD_NEGOVF  = 2'b11
    } guard_e;

endpackage

// File: rtl/lane_addsub.sv
module lane_addsub #(
    parameter int unsigned W = 16
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        // wraps modulo 2^W; the carry-in supplies the +1 of two's complement
        y     = a + b_eff + {{(W-1){1'b0}}, sub};
    end

endmodule

// File: rtl/lane_clamp.sv
module lane_clamp
    import pk_clamp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] res,
    output logic         illegal
);

    localparam int unsigned FRAC_W = W - 2;
    localparam logic [W-1:0] FRAC_MAX = {2'b00, {FRAC_W{1'b1}}};
    localparam logic [W-1:0] FRAC_ZERO = '0;

    guard_e grd;

    always_comb begin
        grd     = guard_e'(raw[W-1 -: 2]);
        res     = raw;
        illegal = 1'b0;
        case (grd)
            GRD_INRANGE: res = raw;
            GRD_POSOVF:  res = FRAC_MAX;
            GRD_NEGOVF:  res = FRAC_ZERO;
            GRD_ILLEGAL: begin
                res     = FRAC_MAX;
                illegal = 1'b1;
            end
            default:     res = raw;
        endcase
    end

endmodule

// File: rtl/pk_clamp_addsub.sv
module pk_clamp_addsub
    import pk_clamp_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned LANES  = LANES_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     op_sub,
    input  logic [LANES*LANE_W-1:0]  opnd_a,
    input  logic [LANES*LANE_W-1:0]  opnd_b,
    output logic                     out_valid,
    output logic [LANES*LANE_W-1:0]  out_data,
    output logic [LANES-1:0]         out_flag
);

    localparam int unsigned DATA_W = LANES * LANE_W;
    localparam int unsigned FRAC_W = LANE_W - 2;
    localparam logic [LANE_W-1:0] FRAC_MAX = {2'b00, {FRAC_W{1'b1}}};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  flag;
    } stage_t;

    stage_t st_d, st_q;

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] clamp_w;
    logic [LANES-1:0]  ill_w;

    // one arithmetic and one clamp slice per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_addsub #(.W(LANE_W)) u_alu (
            .sub (op_sub),
            .a   (opnd_a[g*LANE_W +: LANE_W]),
            .b   (opnd_b[g*LANE_W +: LANE_W]),
            .y   (sum_w[g*LANE_W +: LANE_W])
        );

        lane_clamp #(.W(LANE_W)) u_clp (
            .raw     (sum_w[g*LANE_W +: LANE_W]),
            .res     (clamp_w[g*LANE_W +: LANE_W]),
            .illegal (ill_w[g])
        );

        // R7: a raised flag always comes with the largest fraction in its lane
        a_r7_flag_max: assert property (@(posedge clk) disable iff (rst)
            out_flag[g] |-> (out_data[g*LANE_W +: LANE_W] == FRAC_MAX));

        // R4/R5/R6: the guard bits of a registered lane are always clear
        a_r4_guard_clear: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_data[g*LANE_W + LANE_W - 1 -: 2] == 2'b00));
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.flag = in_valid ? ill_w : '0;
        if (in_valid) begin
            st_d.data = clamp_w;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_flag  = st_q.flag;

    // R8: valid follows the accepted input by one clock
    a_r8_valid_lat: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8: no flag without valid
    a_r8_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_flag == '0));

    // R9: an idle cycle leaves the data untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R10: reset clears everything on the next edge
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_flag == '0 && out_data == '0));

endmodule

// File: tb/tb_pk_clamp_addsub.sv
`timescale 1ns/1ps
module tb_pk_clamp_addsub;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        op_sub;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic        out_valid;
    logic [63:0] out_data;
    logic [3:0]  out_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] exp_data;

    always #2 clk = ~clk;

    pk_clamp_addsub dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_sub    (op_sub),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_flag  (out_flag)
    );

    // expected lane: {flag, 16-bit value}
    function automatic logic [16:0] ref_lane(logic [15:0] a, logic [15:0] b, logic sub);
        logic [15:0] s;
        s = sub ? (a - b) : (a + b);
        case (s[15:14])
            2'b00:   return {1'b0, s};
            2'b01:   return {1'b0, 16'h3FFF};
            2'b11:   return {1'b0, 16'h0000};
            default: return {1'b1, 16'h3FFF};
        endcase
    endfunction

    function automatic logic [67:0] ref_word(logic [63:0] a, logic [63:0] b, logic sub);
        logic [67:0] r;
        logic [16:0] l;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            l = ref_lane(a[16*i +: 16], b[16*i +: 16], sub);
            r[16*i +: 16] = l[15:0];
            r[64 + i]     = l[16];
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one cycle of stimulus, then compare one edge later
    task automatic step(string req, logic v, logic sub, logic [63:0] a, logic [63:0] b);
        logic [67:0] r;
        in_valid = v;
        op_sub   = sub;
        opnd_a   = a;
        opnd_b   = b;
        r = ref_word(a, b, sub);
        if (v) exp_data = r[63:0];
        @(negedge clk);
        chk("R8 valid", {63'd0, out_valid}, {63'd0, v});
        chk({req, " data"}, out_data, exp_data);
        chk("R7/R8 flag", {60'd0, out_flag}, v ? {60'd0, r[67:64]} : 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20230518));
        rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0;
        opnd_a = '0; opnd_b = '0; exp_data = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 valid", {63'd0, out_valid}, 64'd0);
        chk("R10 data", out_data, 64'd0);
        chk("R10 flag", {60'd0, out_flag}, 64'd0);
        rst = 1'b0;

        // R1 R4 R5 R6 R7: one guard pattern per lane, add
        step("R1", 1'b1, 1'b0, 64'h4000_0000_3000_1000, 64'h4000_C000_2000_0234);
        chk("R1 lane map", out_data, 64'h3FFF_0000_3FFF_1234);
        chk("R7 flag lane3", {60'd0, out_flag}, 64'h8);
        // R3 with all patterns, subtract
        step("R3", 1'b1, 1'b1, 64'h0000_3FFF_2000_0005, 64'h7000_C000_1000_0006);
        chk("R5/R6 sub", out_data, 64'h3FFF_3FFF_1000_0000);
        // R2: carry must stay in lane 0
        step("R2", 1'b1, 1'b0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001);
        chk("R2 no carry", out_data, 64'h0);
        // R3: borrow must stay in lane 0
        step("R3", 1'b1, 1'b1, 64'h0000_0000_0005_0000, 64'h0000_0000_0000_0001);
        chk("R3 no borrow", out_data, 64'h0000_0000_0005_0000);
        // R4 exact boundary values
        step("R4", 1'b1, 1'b0, 64'h3FFE_0000_1FFF_0000, 64'h0001_0000_2000_0000);
        chk("R4 boundary", out_data, 64'h3FFF_0000_3FFF_0000);
        // R9: idle cycle holds data, valid and flags low
        step("R9", 1'b0, 1'b0, 64'h4000_4000_4000_4000, 64'h4000_4000_4000_4000);
        chk("R9 hold", out_data, 64'h3FFF_0000_3FFF_0000);
        // R7 on every lane at once
        step("R7", 1'b1, 1'b0, 64'h4000_4000_4000_4000, 64'h4000_4000_4000_4000);
        chk("R7 all flags", {60'd0, out_flag}, 64'hF);

        // random mix of add, subtract and idle cycles
        for (int n = 0; n < 400; n++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            step("R2/R3/R9 rnd", ($urandom % 4) != 0, $urandom % 2, ra, rb);
        end

        // R10: reset in mid-run
        step("R8", 1'b1, 1'b0, 64'h1111_2222_3333_0444, 64'h0001_0002_0003_0004);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 mid valid", {63'd0, out_valid}, 64'd0);
        chk("R10 mid data", out_data, 64'd0);
        chk("R10 mid flag", {60'd0, out_flag}, 64'd0);
        rst = 1'b0;
        exp_data = '0;
        step("R8 after reset", 1'b1, 1'b1, 64'h0010_0020_0030_0040, 64'h0001_0002_0003_0004);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule